// File: doc/BRIEF.md
# Two-Stage Virtual-Channel Switch Arbiter

This block chooses, every cycle, which waiting packets in a multi-port network router may cross the switch. There are eight input ports by default: a cache port, two memory-controller ports, an I/O port and four torus links. Each input holds its packets in a set of queues. Every coherence class (request, forward, response) has its own group of virtual-channel queues. Route computation and storage sit outside the block. Each queue reports whether it has a packet and which output that packet wants. Per output and class, a credit bit says whether the downstream buffer can accept a packet.

Arbitration runs in two stages. At each input, two nominating arbiters each pick one eligible queue. The two picks never share a queue and never target the same output. At each output, one picking arbiter then chooses a single winner among the inputs that nominated it. The winners are registered and returned one cycle later. They appear as a per-queue grant vector and as a per-output vector that identifies the winning input. Responses have their own queues and outrank the other classes, so a stalled or competing request never holds a response back.

Top module: `xbar_two_stage_arb`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `q_grant` and `out_grant` are all zero. All round-robin pointers start at zero.
- R2: Queue j = i*NQ + c*NVC + v has i = input, c = class (0 request, 1 forward, 2 response), v = virtual channel and NQ = NCLS*NVC. Its destination is `q_dest[j*OW +: OW]`. It is eligible only when `q_valid[j]` is high and `credit_ok[dest*NCLS + c]` is high. An ineligible queue is never granted.
- R3: Grants are registered. The inputs sampled at a rising edge decide the grant outputs that are visible after that same edge, and they hold for one cycle.
- R4: The first nominating arbiter at an input picks from the highest eligible class: response over forward over request.
- R5: Within a class, the search starts at that input's pointer for the class and moves upward, wrapping. When a queue of class c is granted through the first arbiter, the pointer becomes (v+1) mod NVC. If the first arbiter got no grant of class c, the second arbiter's grant of class c sets the pointer the same way.
- R6: The second nominating arbiter follows the same ordering. It skips the first arbiter's queue and every queue whose destination equals the first arbiter's destination.
- R7: Each output searches the nominating inputs upward from its pointer, wrapping. After a grant to input i, the pointer becomes (i+1) mod NIN. It does not move in a cycle with no grant.
- R8: `out_grant[o*NIN + i]` is high when output o granted input i. Each output grants at most one input, and each granted input also shows a queue grant.
- R9: A queue is granted at most once per cycle. An input receives at most two queue grants, and they go to different outputs. The number of queue grants equals the number of output grants.
- R10: A request-class queue never blocks a response-class queue at the same input. This holds whether the request lacks credit or competes for the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| q_valid | input | NIN*NQ | Queue holds a packet |
| q_dest | input | NIN*NQ*OW | Requested output of each queue's head packet |
| credit_ok | input | NOUT*NCLS | Downstream credit available per output and class |
| q_grant | output | NIN*NQ | Registered grant per queue |
| out_grant | output | NOUT*NIN | Registered per-output grant vector over inputs |

## Verification
The bench targets five situations, each with the failure it would expose:
- An input holding packets of all three classes at once. A wrong class order shows up as a request grant in place of a response.
- Two virtual channels of one class aimed at a single output. A stuck or skipped pointer gives the same channel every cycle instead of alternating.
- Several queues at one input aimed at the same output. A faulty second-stage mask lets two packets of one input claim one output in the same cycle.
- Several inputs contending for one output across idle gaps. A pointer that moves without a grant breaks the expected rotation.
- A credit-starved request beside a response. A credit check that ignores class either grants the starved packet or holds the response back.

Long random traffic is compared against a behavioural model on every clock.

// File: rtl/xbar_pkg.sv
// Package: class encodings shared by the switch arbiter and its checker.
// Assumes classes are numbered so that a larger code has higher priority.
package xbar_pkg;
    localparam int CLS_REQUEST  = 0;
    localparam int CLS_FORWARD  = 1;
    localparam int CLS_RESPONSE = 2;
    localparam int NUM_CLASSES  = 3;
endpackage

// File: rtl/xbar_local_nom.sv
// Module: per-input pair of nominating arbiters.
// Arbiter A takes the highest eligible class and round-robins between the
// virtual channels of that class. Arbiter B follows the same order but
// avoids A's queue and A's destination. Each class keeps one pointer, which
// moves after a grant.
// Assumes every destination field holds a valid output index.
module xbar_local_nom #(
    parameter int NCLS = 3,
    parameter int NVC  = 2,
    parameter int OW   = 3,
    localparam int NQ  = NCLS * NVC,
    localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int VW  = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int CW  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ-1:0]    elig,
    input  logic [NQ*OW-1:0] dest,
    input  logic             grant_a,
    input  logic             grant_b,
    output logic             a_v,
    output logic [QW-1:0]    a_q,
    output logic [OW-1:0]    a_d,
    output logic             b_v,
    output logic [QW-1:0]    b_q,
    output logic [OW-1:0]    b_d
);
    logic [VW-1:0] ptr [NCLS];
    logic [CW-1:0] a_cls, b_cls;
    logic [VW-1:0] a_vc, b_vc;

    // Arbiter A: class priority first, then round-robin over channels.
    always_comb begin
        a_v = 1'b0; a_q = '0; a_cls = '0; a_vc = '0;
        for (int c = NCLS - 1; c >= 0; c--) begin
            for (int k = 0; k < NVC; k++) begin
                int v;
                v = int'(ptr[c]) + k;
                if (v >= NVC) v = v - NVC;
                if (!a_v && elig[c*NVC + v]) begin
                    a_v = 1'b1; a_q = QW'(c*NVC + v); a_cls = CW'(c); a_vc = VW'(v);
                end
            end
        end
    end

    assign a_d = dest[int'(a_q)*OW +: OW];

    // Arbiter B: same order, masked by A's queue and A's destination.
    always_comb begin
        b_v = 1'b0; b_q = '0; b_cls = '0; b_vc = '0;
        for (int c = NCLS - 1; c >= 0; c--) begin
            for (int k = 0; k < NVC; k++) begin
                int v;
                int q;
                v = int'(ptr[c]) + k;
                if (v >= NVC) v = v - NVC;
                q = c*NVC + v;
                if (!b_v && elig[q] &&
                    !(a_v && (QW'(q) == a_q || dest[q*OW +: OW] == a_d))) begin
                    b_v = 1'b1; b_q = QW'(q); b_cls = CW'(c); b_vc = VW'(v);
                end
            end
        end
    end

    assign b_d = dest[int'(b_q)*OW +: OW];

    // Pointer update: a grant through A has precedence over one through B.
    always_ff @(posedge clk) begin
        for (int c = 0; c < NCLS; c++) begin
            if (!rst_n) begin
                ptr[c] <= '0;
            end else if (grant_a && a_cls == CW'(c)) begin
                ptr[c] <= (a_vc == VW'(NVC - 1)) ? '0 : a_vc + 1'b1;
            end else if (grant_b && b_cls == CW'(c)) begin
                ptr[c] <= (b_vc == VW'(NVC - 1)) ? '0 : b_vc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbar_global_pick.sv
// Module: per-output round-robin picking arbiter.
// Chooses one requesting input, searching upward from its pointer.
// The pointer moves past the winner only when a grant is made.
module xbar_global_pick #(
    parameter int NIN = 8,
    localparam int IW = (NIN > 1) ? $clog2(NIN) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] req,
    output logic           win_v,
    output logic [IW-1:0]  win_i
);
    logic [IW-1:0] ptr;

    // Winner search starting at the pointer, wrapping.
    always_comb begin
        win_v = 1'b0; win_i = '0;
        for (int k = 0; k < NIN; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= NIN) idx = idx - NIN;
            if (!win_v && req[idx]) begin
                win_v = 1'b1; win_i = IW'(idx);
            end
        end
    end

    // Pointer advance after a grant only.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (win_v) ptr <= (win_i == IW'(NIN - 1)) ? '0 : win_i + 1'b1;
    end
endmodule

// File: rtl/xbar_two_stage_arb.sv
// Module: two-stage switch arbiter (top).
// Per input, a pair of nominating arbiters; per output, a picking arbiter.
// Grants are registered. A requester that keeps its valid high after a
// grant is treated as holding a further packet.
module xbar_two_stage_arb #(
    parameter int NIN  = 8,
    parameter int NOUT = 8,
    parameter int NCLS = xbar_pkg::NUM_CLASSES,
    parameter int NVC  = 2,
    localparam int NQ  = NCLS * NVC,
    localparam int OW  = (NOUT > 1) ? $clog2(NOUT) : 1,
    localparam int IW  = (NIN > 1) ? $clog2(NIN) : 1,
    localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NIN*NQ-1:0]       q_valid,
    input  logic [NIN*NQ*OW-1:0]    q_dest,
    input  logic [NOUT*NCLS-1:0]    credit_ok,
    output logic [NIN*NQ-1:0]       q_grant,
    output logic [NOUT*NIN-1:0]     out_grant
);
    logic [NIN*NQ-1:0] elig;
    logic              nom_a_v [NIN];
    logic              nom_b_v [NIN];
    logic [QW-1:0]     nom_a_q [NIN];
    logic [QW-1:0]     nom_b_q [NIN];
    logic [OW-1:0]     nom_a_d [NIN];
    logic [OW-1:0]     nom_b_d [NIN];
    logic              gnt_a   [NIN];
    logic              gnt_b   [NIN];
    logic [NIN-1:0]    greq    [NOUT];
    logic              win_v   [NOUT];
    logic [IW-1:0]     win_i   [NOUT];
    logic [NIN*NQ-1:0]   q_grant_nxt;
    logic [NOUT*NIN-1:0] out_grant_nxt;

    // Eligibility: a packet is present and its output/class has a credit.
    always_comb begin
        for (int j = 0; j < NIN*NQ; j++) begin
            int d;
            d = int'(q_dest[j*OW +: OW]);
            elig[j] = q_valid[j] && credit_ok[d*NCLS + (j % NQ) / NVC];
        end
    end

    for (genvar i = 0; i < NIN; i++) begin : g_in
        xbar_local_nom #(.NCLS(NCLS), .NVC(NVC), .OW(OW)) u_nom (
            .clk(clk), .rst_n(rst_n),
            .elig(elig[i*NQ +: NQ]), .dest(q_dest[i*NQ*OW +: NQ*OW]),
            .grant_a(gnt_a[i]), .grant_b(gnt_b[i]),
            .a_v(nom_a_v[i]), .a_q(nom_a_q[i]), .a_d(nom_a_d[i]),
            .b_v(nom_b_v[i]), .b_q(nom_b_q[i]), .b_d(nom_b_d[i]));
    end

    // Request matrix: input i asks output o if either nominee targets o.
    always_comb begin
        for (int o = 0; o < NOUT; o++) begin
            for (int i = 0; i < NIN; i++) begin
                greq[o][i] = (nom_a_v[i] && nom_a_d[i] == OW'(o)) ||
                             (nom_b_v[i] && nom_b_d[i] == OW'(o));
            end
        end
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        xbar_global_pick #(.NIN(NIN)) u_pick (
            .clk(clk), .rst_n(rst_n), .req(greq[o]),
            .win_v(win_v[o]), .win_i(win_i[o]));
    end

    // Return path: which nominee of each input won its output.
    always_comb begin
        for (int i = 0; i < NIN; i++) begin
            gnt_a[i] = nom_a_v[i] && win_v[nom_a_d[i]] && win_i[nom_a_d[i]] == IW'(i);
            gnt_b[i] = nom_b_v[i] && win_v[nom_b_d[i]] && win_i[nom_b_d[i]] == IW'(i);
        end
    end

    // Next-state grant vectors for queues and outputs.
    always_comb begin
        q_grant_nxt   = '0;
        out_grant_nxt = '0;
        for (int i = 0; i < NIN; i++) begin
            if (gnt_a[i]) q_grant_nxt[i*NQ + int'(nom_a_q[i])] = 1'b1;
            if (gnt_b[i]) q_grant_nxt[i*NQ + int'(nom_b_q[i])] = 1'b1;
        end
        for (int o = 0; o < NOUT; o++) begin
            if (win_v[o]) out_grant_nxt[o*NIN + int'(win_i[o])] = 1'b1;
        end
    end

    // Output registers: one-cycle grant latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_grant   <= '0;
            out_grant <= '0;
        end else begin
            q_grant   <= q_grant_nxt;
            out_grant <= out_grant_nxt;
        end
    end
endmodule

// File: rtl/xbar_arb_chk.sv
// Module: assertion checker for the two-stage switch arbiter.
// Uses only the top-level ports and is attached with a bind.
module xbar_arb_chk #(
    parameter int NIN  = 8,
    parameter int NOUT = 8,
    parameter int NCLS = 3,
    parameter int NVC  = 2,
    localparam int NQ  = NCLS * NVC,
    localparam int OW  = (NOUT > 1) ? $clog2(NOUT) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NIN*NQ-1:0]    q_valid,
    input logic [NIN*NQ*OW-1:0] q_dest,
    input logic [NOUT*NCLS-1:0] credit_ok,
    input logic [NIN*NQ-1:0]    q_grant,
    input logic [NOUT*NIN-1:0]  out_grant
);
    logic [NIN*NQ-1:0] ok;

    // Port-level eligibility, used to judge grants a cycle later.
    always_comb begin
        for (int j = 0; j < NIN*NQ; j++) begin
            ok[j] = q_valid[j] &&
                    credit_ok[int'(q_dest[j*OW +: OW])*NCLS + (j % NQ) / NVC];
        end
    end

    for (genvar j = 0; j < NIN*NQ; j++) begin : g_q
        AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
            q_grant[j] |-> $past(ok[j])); // R2
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_o
        AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(out_grant[o*NIN +: NIN])); // R8
        for (genvar i = 0; i < NIN; i++) begin : g_i
            AST_OUT_HAS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
                out_grant[o*NIN + i] |-> (|q_grant[i*NQ +: NQ])); // R8
        end
    end

    for (genvar i = 0; i < NIN; i++) begin : g_in
        AST_INPUT_TWO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(q_grant[i*NQ +: NQ]) <= 2); // R9
    end

    AST_GRANT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_grant) == $countones(out_grant)); // R9
endmodule

bind xbar_two_stage_arb xbar_arb_chk #(.NIN(NIN), .NOUT(NOUT), .NCLS(NCLS), .NVC(NVC)) u_chk (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_dest(q_dest),
    .credit_ok(credit_ok), .q_grant(q_grant), .out_grant(out_grant));

// File: tb/sim_xbar_two_stage_arb.sv
// Bench: behavioural reference model compared on every clock.
module sim_xbar_two_stage_arb;
    localparam int PERIOD = 10;
    localparam int NIN = 8, NOUT = 8, NCLS = 3, NVC = 2;
    localparam int NQ = NCLS * NVC, OW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NIN*NQ-1:0]    q_valid = '0;
    logic [NIN*NQ*OW-1:0] q_dest = '0;
    logic [NOUT*NCLS-1:0] credit_ok = '0;
    logic [NIN*NQ-1:0]    q_grant;
    logic [NOUT*NIN-1:0]  out_grant;

    int checks = 0, fails = 0;
    int lptr [NIN][NCLS];
    int gptr [NOUT];
    logic [NIN*NQ-1:0]   expq;
    logic [NOUT*NIN-1:0] expo;

    always #(PERIOD/2) clk = ~clk;

    xbar_two_stage_arb #(.NIN(NIN), .NOUT(NOUT), .NCLS(NCLS), .NVC(NVC)) u0 (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_dest(q_dest),
        .credit_ok(credit_ok), .q_grant(q_grant), .out_grant(out_grant));

    function automatic int dst(int i, int q);
        return int'(q_dest[(i*NQ + q)*OW +: OW]);
    endfunction

    function automatic bit elig(int i, int q);
        return q_valid[i*NQ + q] && credit_ok[dst(i, q)*NCLS + q / NVC];
    endfunction

    // Model one arbitration round; set expected grants and move pointers.
    task automatic model_round();
        int a [NIN];
        int b [NIN];
        bit ga [NIN];
        bit gb [NIN];
        expq = '0; expo = '0;
        for (int i = 0; i < NIN; i++) begin
            a[i] = -1; b[i] = -1; ga[i] = 0; gb[i] = 0;
            for (int c = NCLS - 1; c >= 0; c--)
                for (int k = 0; k < NVC; k++) begin
                    int q;
                    q = c*NVC + (lptr[i][c] + k) % NVC;
                    if (a[i] < 0 && elig(i, q)) a[i] = q;
                end
            for (int c = NCLS - 1; c >= 0; c--)
                for (int k = 0; k < NVC; k++) begin
                    int q;
                    q = c*NVC + (lptr[i][c] + k) % NVC;
                    if (b[i] < 0 && elig(i, q) &&
                        !(a[i] >= 0 && (q == a[i] || dst(i, q) == dst(i, a[i]))))
                        b[i] = q;
                end
        end
        for (int o = 0; o < NOUT; o++) begin
            int w;
            w = -1;
            for (int k = 0; k < NIN; k++) begin
                int i;
                i = (gptr[o] + k) % NIN;
                if (w < 0 && ((a[i] >= 0 && dst(i, a[i]) == o) ||
                              (b[i] >= 0 && dst(i, b[i]) == o))) w = i;
            end
            if (w >= 0) begin
                expo[o*NIN + w] = 1'b1;
                gptr[o] = (w + 1) % NIN;
                if (a[w] >= 0 && dst(w, a[w]) == o) begin
                    ga[w] = 1; expq[w*NQ + a[w]] = 1'b1;
                end else begin
                    gb[w] = 1; expq[w*NQ + b[w]] = 1'b1;
                end
            end
        end
        for (int i = 0; i < NIN; i++) begin
            if (ga[i]) lptr[i][a[i] / NVC] = (a[i] % NVC + 1) % NVC;
            if (gb[i] && !(ga[i] && a[i] / NVC == b[i] / NVC))
                lptr[i][b[i] / NVC] = (b[i] % NVC + 1) % NVC;
        end
    endtask

    task automatic compare(string tag);
        checks++;
        if (q_grant !== expq) begin
            fails++;
            $display("FAIL %s q_grant actual=%h expected=%h", tag, q_grant, expq);
        end
        checks++;
        if (out_grant !== expo) begin
            fails++;
            $display("FAIL %s out_grant actual=%h expected=%h", tag, out_grant, expo);
        end
    endtask

    // Inputs are already set (at a falling edge); run one clock and compare.
    task automatic step(string tag);
        model_round();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic clr();
        q_valid = '0; q_dest = '0; credit_ok = '1;
    endtask

    task automatic setq(int i, int c, int v, int d);
        int j;
        j = i*NQ + c*NVC + v;
        q_valid[j] = 1'b1;
        q_dest[j*OW +: OW] = OW'(d);
    endtask

    initial begin
        for (int i = 0; i < NIN; i++) for (int c = 0; c < NCLS; c++) lptr[i][c] = 0;
        for (int o = 0; o < NOUT; o++) gptr[o] = 0;
        expq = '0; expo = '0;
        // R1: outputs stay zero while reset is held, even with traffic offered.
        credit_ok = '1;
        setq(0, 2, 0, 1);
        repeat (3) begin
            @(negedge clk);
            compare("R1");
        end
        clr();
        rst_n = 1'b1;
        step("R1");
        // R2: a queue without credit is not granted; it is once credit returns.
        setq(0, 0, 0, 3);
        credit_ok[3*NCLS + 0] = 1'b0;
        step("R2"); step("R2");
        credit_ok[3*NCLS + 0] = 1'b1;
        step("R2");
        // R3: a single-cycle request yields exactly one grant cycle.
        clr(); setq(2, 1, 1, 4);
        step("R3");
        clr();
        step("R3"); step("R3");
        // R4: all three classes present; the response goes first.
        setq(0, 0, 0, 1); setq(0, 1, 0, 2); setq(0, 2, 0, 3);
        step("R4"); step("R4");
        // R5: two response channels to one output alternate.
        clr(); setq(0, 2, 0, 1); setq(0, 2, 1, 1);
        repeat (4) step("R5");
        // R6: same destination at one input; the second arbiter moves on.
        clr(); setq(1, 2, 0, 6); setq(1, 1, 0, 6); setq(1, 0, 1, 7);
        repeat (3) step("R6");
        // R7: four inputs contend for one output, with idle gaps.
        clr();
        for (int i = 0; i < 4; i++) setq(i, 0, 0, 5);
        repeat (3) step("R7");
        clr(); step("R7"); step("R7");
        for (int i = 0; i < 4; i++) setq(i, 0, 0, 5);
        repeat (3) step("R7");
        // R10: a starved request beside a response; then both share an output.
        clr(); setq(3, 0, 0, 2); setq(3, 2, 1, 2);
        credit_ok[2*NCLS + 0] = 1'b0;
        step("R10"); step("R10");
        credit_ok[2*NCLS + 0] = 1'b1;
        step("R10"); step("R10");
        // R8 R9: random traffic with sparse credit loss.
        for (int n = 0; n < 3000; n++) begin
            for (int j = 0; j < NIN*NQ; j++) begin
                q_valid[j] = ($urandom % 3) != 0;
                q_dest[j*OW +: OW] = OW'($urandom % NOUT);
            end
            for (int k = 0; k < NOUT*NCLS; k++) credit_ok[k] = ($urandom % 5) != 0;
            step("R8 R9");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule